// File: doc/BRIEF.md
# Radix-4 Signed-Digit Multiplier Recoder with Pair Folding

This block prepares the partial-product rows of a signed multiply. It takes a two's-complement multiplier of even width W and splits it into W/2 radix-4 signed digits, each drawn from an overlapping window of three multiplier bits, with the bit below the least significant bit taken as 0. Each digit lies in the set {-2, -1, 0, +1, +2}. A second, combinational pass then walks the digits from the most significant end down. Whenever a digit of magnitude one sits directly above a digit of magnitude two with the opposite sign, the pass folds the pair into a zero and a magnitude-two digit. This leaves fewer non-zero partial products for the adder tree that follows.

For every digit the block drives three select lines: one-times, two-times and negate. It also drives the partial-product row those selects pick from the signed multiplicand, and a count of the digits that are not zero. Adding the rows together is left to a separate adder tree.

Operands enter on a valid/ready stream and results leave on another one, with one register stage between them. An input is taken on any edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, every output holds its value and no new operand is taken.

Top module: `booth4_merge_enc`

## Requirements
- R1: Before folding, digit i is -2*Y[2i+1] + Y[2i] + Y[2i-1], with Y[-1] = 0.
- R2: Digit selects use this encoding: magnitude 1 sets `out_one[i]`, magnitude 2 sets `out_two[i]`, and a negative value sets `out_neg[i]`. A zero digit, which includes the bit windows 000 and 111, sets none of the three.
- R3: Folding runs from the top pair, digits (ND-1, ND-2), down to the pair (1, 0). Each pair is tested after any rewrite made by the pair above it. The pair (-1,+2) becomes (0,-2) and the pair (+1,-2) becomes (0,+2).
- R4: The sum of all output digits, each weighted by 4^i, equals Y read as a signed number.
- R5: Row i occupies bits [i*(XW+2) +: XW+2] of `out_rows`. For a positive digit it holds |d|*X sign-extended to XW+2 bits. For a negative digit it holds the bitwise inverse of that value, and the +1 needed to complete the negation is `out_neg[i]`, added at the row's least significant position. Adding up (row + neg) * 4^i over all rows gives X*Y.
- R6: `out_nz` equals the number of digits that are not zero after folding.
- R7: An input is taken when `in_valid` and `in_ready` are both high. `in_ready` equals `!out_valid || out_ready`. While the output is stalled, all outputs stay stable.
- R8: While reset is held and just after it, `out_valid` is 0 and `in_ready` is 1.
- R9: The result appears on the outputs at the clock edge after the operand is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can take an operand pair |
| in_mcand | input | XW | Signed multiplicand X |
| in_mplr | input | W | Signed multiplier Y |
| out_valid | output | 1 | Result held on outputs |
| out_ready | input | 1 | Consumer takes the result |
| out_one | output | W/2 | Per-digit one-times select |
| out_two | output | W/2 | Per-digit two-times select |
| out_neg | output | W/2 | Per-digit negate and +1 correction bit |
| out_rows | output | (W/2)*(XW+2) | Partial-product rows, row i in slice i |
| out_nz | output | clog2(W/2+1) | Count of non-zero digits |

## Verification
The bench sweeps every multiplier value at widths 8 and 6 against several multiplicands, including the most negative one. For each result it compares the exact digits, checks that the digits sum back to Y, and checks that the rows sum back to X*Y. A fold applied right to left, or applied only to the original digits, would give the wrong digits on chained patterns. A fold that sets the wrong sign would break the digit sum. Forgetting the correction bit, or sign-extending the row too narrowly, would break the product sum at -128 and at the doubled multiples. Directed cases hit the two fold patterns, the all-zero and all-one windows, and a stalled output. A design that drops or overwrites a held result under back-pressure would show changed outputs or a raised `in_ready` while stalled.

// File: rtl/booth4_pkg.sv
package booth4_pkg;
  // 3-bit two's-complement digit codes
  localparam logic [2:0] DIG_Z  = 3'b000;
  localparam logic [2:0] DIG_P1 = 3'b001;
  localparam logic [2:0] DIG_P2 = 3'b010;
  localparam logic [2:0] DIG_M2 = 3'b110;
  localparam logic [2:0] DIG_M1 = 3'b111;

  // window = {upper, middle, lower} multiplier bits
  function automatic logic [2:0] window_digit(input logic [2:0] win);
    case (win)
      3'b001, 3'b010: window_digit = DIG_P1;
      3'b011:         window_digit = DIG_P2;
      3'b100:         window_digit = DIG_M2;
      3'b101, 3'b110: window_digit = DIG_M1;
      default:        window_digit = DIG_Z;
    endcase
  endfunction
endpackage

// File: rtl/booth4_digit_enc.sv
module booth4_digit_enc
  import booth4_pkg::*;
#(
  parameter int ND = 4
) (
  input  logic [2*ND-1:0]     mplr,
  output logic [ND-1:0][2:0]  dig
);
  logic [2*ND:0] ext;
  assign ext = {mplr, 1'b0};

  for (genvar i = 0; i < ND; i++) begin : g_dig
    assign dig[i] = window_digit(ext[2*i+2 -: 3]);
  end
endmodule

// File: rtl/booth4_pair_merge.sv
module booth4_pair_merge
  import booth4_pkg::*;
#(
  parameter int ND = 4
) (
  input  logic [ND-1:0][2:0] dig_in,
  output logic [ND-1:0][2:0] dig_out
);
  logic [ND-1:0][2:0] work;

  always_comb begin
    work = dig_in;
    for (int i = ND - 1; i >= 1; i--) begin
      if (work[i] == DIG_M1 && work[i-1] == DIG_P2) begin
        work[i]   = DIG_Z;
        work[i-1] = DIG_M2;
      end else if (work[i] == DIG_P1 && work[i-1] == DIG_M2) begin
        work[i]   = DIG_Z;
        work[i-1] = DIG_P2;
      end
    end
    dig_out = work;
  end
endmodule

// File: rtl/booth4_row_gen.sv
module booth4_row_gen
  import booth4_pkg::*;
#(
  parameter int ND = 4,
  parameter int XW = 8,
  localparam int RW = XW + 2,
  localparam int CW = $clog2(ND + 1)
) (
  input  logic [ND-1:0][2:0]    dig,
  input  logic [XW-1:0]         mcand,
  output logic [ND-1:0]         sel_one,
  output logic [ND-1:0]         sel_two,
  output logic [ND-1:0]         sel_neg,
  output logic [ND-1:0][RW-1:0] rows,
  output logic [CW-1:0]         nz_cnt
);
  logic [RW-1:0] sx;
  assign sx = {{2{mcand[XW-1]}}, mcand};

  for (genvar i = 0; i < ND; i++) begin : g_row
    logic [RW-1:0] mult;
    assign sel_one[i] = (dig[i] == DIG_P1) || (dig[i] == DIG_M1);
    assign sel_two[i] = (dig[i] == DIG_P2) || (dig[i] == DIG_M2);
    assign sel_neg[i] = dig[i][2];
    assign mult    = sel_two[i] ? {sx[RW-2:0], 1'b0} : (sel_one[i] ? sx : '0);
    assign rows[i] = sel_neg[i] ? ~mult : mult;
  end

  always_comb begin
    nz_cnt = '0;
    for (int i = 0; i < ND; i++) begin
      if (dig[i] != DIG_Z) nz_cnt = nz_cnt + CW'(1);
    end
  end
endmodule

// File: rtl/booth4_merge_enc.sv
module booth4_merge_enc
  import booth4_pkg::*;
#(
  parameter int W  = 8,
  parameter int XW = 8,
  localparam int ND = W / 2,
  localparam int RW = XW + 2,
  localparam int CW = $clog2(ND + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [XW-1:0]    in_mcand,
  input  logic [W-1:0]     in_mplr,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ND-1:0]    out_one,
  output logic [ND-1:0]    out_two,
  output logic [ND-1:0]    out_neg,
  output logic [ND*RW-1:0] out_rows,
  output logic [CW-1:0]    out_nz
);
  logic [ND-1:0][2:0]    raw_dig, fold_dig;
  logic [ND-1:0]         c_one, c_two, c_neg;
  logic [ND-1:0][RW-1:0] c_rows;
  logic [CW-1:0]         c_nz;
  logic                  take;

  booth4_digit_enc #(.ND(ND)) u_enc (.mplr(in_mplr), .dig(raw_dig));

  booth4_pair_merge #(.ND(ND)) u_merge (.dig_in(raw_dig), .dig_out(fold_dig));

  booth4_row_gen #(.ND(ND), .XW(XW)) u_rows (
    .dig(fold_dig), .mcand(in_mcand),
    .sel_one(c_one), .sel_two(c_two), .sel_neg(c_neg),
    .rows(c_rows), .nz_cnt(c_nz)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_one   <= '0;
      out_two   <= '0;
      out_neg   <= '0;
      out_rows  <= '0;
      out_nz    <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take) begin
        out_one  <= c_one;
        out_two  <= c_two;
        out_neg  <= c_neg;
        out_rows <= c_rows;
        out_nz   <= c_nz;
      end
    end
  end

  // R2: one-times and two-times are exclusive; negate only with a non-zero digit
  a_r2_sel_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_one & out_two) == '0));
  a_r2_neg_needs_mag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_neg & ~(out_one | out_two)) == '0));
  // R6: count agrees with the registered selects
  a_r6_nz_count: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_nz) == $countones(out_one | out_two)));
  // R7: a stalled result stays put
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rows) && $stable(out_neg)
                                   && $stable(out_one) && $stable(out_two) && $stable(out_nz)));
  // R3: no foldable pair survives
  for (genvar i = 1; i < ND; i++) begin : g_chk
    a_r3_no_fold_left: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_one[i] && out_two[i-1] && (out_neg[i] != out_neg[i-1])));
  end
endmodule

// File: tb/booth4_merge_enc_tb.sv
`timescale 1ns/1ps
module booth4_merge_enc_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  // 8-bit multiplier instance
  logic        in_valid = 1'b0, out_ready = 1'b1;
  logic        in_ready, out_valid;
  logic [7:0]  in_mcand = '0, in_mplr = '0;
  logic [3:0]  out_one, out_two, out_neg;
  logic [39:0] out_rows;
  logic [2:0]  out_nz;

  booth4_merge_enc #(.W(8), .XW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mcand(in_mcand), .in_mplr(in_mplr), .out_valid(out_valid), .out_ready(out_ready),
    .out_one(out_one), .out_two(out_two), .out_neg(out_neg), .out_rows(out_rows), .out_nz(out_nz)
  );

  // 6-bit multiplier instance
  logic        v6 = 1'b0;
  logic        r6_in, v6_out;
  logic [7:0]  x6 = '0;
  logic [5:0]  y6 = '0;
  logic [2:0]  one6, two6, neg6;
  logic [29:0] rows6;
  logic [1:0]  nz6;

  booth4_merge_enc #(.W(6), .XW(8)) u_dut6 (
    .clk(clk), .rst_n(rst_n), .in_valid(v6), .in_ready(r6_in),
    .in_mcand(x6), .in_mplr(y6), .out_valid(v6_out), .out_ready(1'b1),
    .out_one(one6), .out_two(two6), .out_neg(neg6), .out_rows(rows6), .out_nz(nz6)
  );

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    report();
  end

  task automatic cmp(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Check one result of width w against the requirements
  task automatic check_res(input int w, input int y, input int x,
                           input logic [3:0] one, input logic [3:0] two, input logic [3:0] neg,
                           input logic [39:0] rows, input int nz);
    int nd = w / 2;
    int d[4];
    int ys, b0, b1, b2, nzx, mism_sel, mism_row;
    longint dsum, psum, act_sum;
    ys = (y >= (1 << (w - 1))) ? y - (1 << w) : y;
    for (int i = 0; i < nd; i++) begin
      b2 = (y >> (2*i+1)) & 1;
      b1 = (y >> (2*i)) & 1;
      b0 = (i == 0) ? 0 : ((y >> (2*i-1)) & 1);
      d[i] = -2*b2 + b1 + b0;                      // R1
    end
    for (int i = nd - 1; i >= 1; i--) begin      // R3
      if (d[i] == -1 && d[i-1] == 2) begin d[i] = 0; d[i-1] = -2; end
      else if (d[i] == 1 && d[i-1] == -2) begin d[i] = 0; d[i-1] = 2; end
    end
    mism_sel = 0; mism_row = 0; nzx = 0; act_sum = 0; psum = 0; dsum = 0;
    for (int i = 0; i < nd; i++) begin
      int mag = (d[i] < 0) ? -d[i] : d[i];
      int ad;
      logic [9:0] er, ar;
      if (one[i] !== (mag == 1) || two[i] !== (mag == 2) || neg[i] !== (d[i] < 0))
        mism_sel++;
      ad = (one[i] ? 1 : (two[i] ? 2 : 0)) * (neg[i] ? -1 : 1);
      act_sum += longint'(ad) <<< (2*i);
      dsum += longint'(d[i]) <<< (2*i);
      er = 10'(mag * x);
      if (d[i] < 0) er = ~er;
      ar = rows[i*10 +: 10];
      if (ar !== er) mism_row++;
      psum += (longint'($signed(ar)) + (neg[i] ? 1 : 0)) <<< (2*i);
      if (d[i] != 0) nzx++;
    end
    cmp("R1/R3 digits R2 selects", mism_sel, 0);
    cmp("R4 digit sum", act_sum, ys);
    cmp("R5 row bits", mism_row, 0);
    cmp("R5 row product", psum, longint'(x) * ys);
    cmp("R6 nonzero count", nz, nzx);
    if (dsum != ys) begin n_bad++; $display("FAIL R4 model: actual %0d expected %0d", dsum, ys); end
  endtask

  task automatic send8(input int y, input int x);
    @(negedge clk);
    in_mplr = 8'(y); in_mcand = 8'(x); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    cmp("R9 out_valid after take", out_valid, 1);
    check_res(8, y, x, out_one, out_two, out_neg, out_rows, out_nz);
  endtask

  task automatic t_reset();
    #1;
    cmp("R8 out_valid in reset", out_valid, 0);
    cmp("R8 in_ready in reset", in_ready, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R8 out_valid after reset", out_valid, 0);
    cmp("R8 in_ready after reset", in_ready, 1);
  endtask

  task automatic t_fold_patterns();
    // Y=54: raw digits (+1,-1,+2,-2) fold (R3) to (+1,0,-2,-2)
    send8(54, 3);
    cmp("R3 fold (-1,+2) digit2 zero", out_one[2] | out_two[2], 0);
    cmp("R3 fold (-1,+2) digit1 is -2", {out_two[1], out_neg[1]}, 2'b11);
    // Y=8: raw (0,+1,-2,0) fold to (0,0,+2,0)
    send8(8, -5);
    cmp("R3 fold (+1,-2) digit1 is +2", {out_two[1], out_neg[1], out_one[1]}, 3'b100);
    cmp("R6 single digit after fold", out_nz, 1);
  endtask

  task automatic t_zero_windows();
    send8(0, -128);  // all windows 000
    cmp("R2 zero multiplier selects", {out_one, out_two, out_neg}, 0);
    cmp("R2 zero rows", out_rows, 0);
    send8(255, 77);  // Y=-1: upper windows 111, lowest 110
    cmp("R2 window 111 selects", {out_one[3:1], out_two[3:1], out_neg[3:1]}, 0);
    cmp("R5 only row0 negated", out_neg, 4'b0001);
  endtask

  task automatic t_stall();
    @(negedge clk);
    out_ready = 1'b0;
    send8(54, 3);
    @(negedge clk);
    in_mplr = 8'd8; in_mcand = 8'(5); in_valid = 1'b1;
    #0.1;
    cmp("R7 in_ready low while stalled", in_ready, 0);
    repeat (3) @(negedge clk);
    cmp("R7 held valid", out_valid, 1);
    check_res(8, 54, 3, out_one, out_two, out_neg, out_rows, out_nz);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    cmp("R7 next taken on drain", out_valid, 1);
    check_res(8, 8, 5, out_one, out_two, out_neg, out_rows, out_nz);
    @(negedge clk);
    cmp("R7 empty after drain", out_valid, 0);
  endtask

  task automatic t_sweep8();
    int xs[6] = '{-128, -1, 0, 1, 77, 127};
    for (int xi = 0; xi < 6; xi++)
      for (int y = 0; y < 256; y++) send8(y, xs[xi]);
  endtask

  task automatic t_sweep6();
    int xs[4] = '{-128, -37, 1, 127};
    for (int xi = 0; xi < 4; xi++)
      for (int y = 0; y < 64; y++) begin
        @(negedge clk);
        y6 = 6'(y); x6 = 8'(xs[xi]); v6 = 1'b1;
        @(negedge clk);
        v6 = 1'b0;
        cmp("R9 w6 out_valid", v6_out, 1);
        check_res(6, y, xs[xi], {1'b0, one6}, {1'b0, two6}, {1'b0, neg6},
                  {10'd0, rows6}, int'(nz6));
      end
  endtask

  initial begin
    t_reset();
    t_fold_patterns();
    t_zero_windows();
    t_stall();
    t_sweep8();
    t_sweep6();
    report();
  end
endmodule